// File: doc/BRIEF.md
# Stream Identifier Span Filter

This block decides, for each of a set of performance counters, whether the transaction currently presented should be counted. It takes the transaction's stream identifier and compares it against each counter's programmed filter settings. Each setting has an enable bit, a span bit and a 32-bit match word. The result is one hit flag per counter. A combinational flag is given for same-cycle use, and a registered copy is given for a counter increment path that needs a flop boundary.

With span clear, the comparison is exact on every implemented identifier bit. With span set, the match word carries its own don't-care range. The run of ones at its bottom, together with the first zero above that run, marks the low bits that are ignored. The bits above that zero must match. A disabled filter counts everything. In the default filter setting (span set, match word all ones) the whole word is don't-care, so that setting also counts everything.

A shared-filter option makes counter 0's settings govern every counter. This option is either selected at run time through an input pin, or fixed by a parameter at build time. Only the low `SID_W` bits of a match word take part in the decision.

Top module: `sid_filter`

## Requirements
- R1: With the filter enabled and span clear, a counter hits exactly when the stream identifier equals bits [SID_W-1:0] of its match word.
- R2: With the filter enabled and span set, let Y-1 be the position of the lowest zero bit of the match word's low SID_W bits. Bits Y-1..0 are ignored, and a counter hits exactly when identifier bits SID_W-1..Y equal the same match bits.
- R3: A match word of 0x42 with span set hits for identifiers 0x42 and 0x43 and misses for every other identifier, including 0x40, 0x41, 0x44 and 0x45.
- R4: With span set and match bits [SID_W-1:0] all ones, every identifier hits.
- R5: With the enable bit clear, the counter hits for every identifier, whatever its span bit and match word hold.
- R6: With the shared-filter input high (run-time variant), every counter's hit follows counter 0's enable, span and match word, and the settings of counters 1 and up have no effect.
- R7: With the shared-filter input low, each counter is decided by its own settings alone.
- R8: `hit_reg` is cleared to zero while reset is low, and after each rising clock edge it holds the value that `hit_now` had just before that edge.
- R9: Match-word bits at and above position SID_W have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered hit flags |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_sel | input | 1 | High: counter 0's settings apply to all counters (run-time variant) |
| sid_in | input | SID_W | Stream identifier of the current transaction |
| flt_en | input | NCTR | Per-counter filter enable; bit i belongs to counter i |
| span_sel | input | NCTR | Per-counter span mode; bit i belongs to counter i |
| match_val | input | NCTR*32 | Per-counter match words; counter i uses bits [32*i+31 : 32*i] |
| hit_now | output | NCTR | Combinational hit flag per counter |
| hit_reg | output | NCTR | Registered hit flag per counter |

## Verification
Exact-mode words are tried against identifiers equal to them and against identifiers one bit away. This shows whether any low bit is wrongly treated as don't-care. Span-mode words with zero, one and several trailing ones are tried against identifiers that differ only inside the don't-care range and against identifiers that differ just above it. This shows an off-by-one in the mask boundary. All-ones words, disabled filters and match words with junk in the upper bits show the always-hit cases and the width cut. The same settings are applied with the shared-filter input high and then low, which shows whether counter 0's settings are steered to the other counters or ignored.

// File: rtl/sidf_pkg.sv
package sidf_pkg;

   // Width of a programmed match word, independent of the implemented identifier width
   localparam int unsigned WORD_W = 32;

   // How counter settings are routed to the comparators
   typedef enum logic [1:0] {
      SEL_RUNTIME = 2'd0,   // glob_sel pin chooses shared or per-counter
      SEL_LOCAL   = 2'd1,   // always per-counter
      SEL_SHARED  = 2'd2    // always counter 0 for everyone
   } sel_mode_e;

   typedef struct packed {
      logic              en;
      logic              span;
      logic [WORD_W-1:0] word;
   } flt_cfg_t;

endpackage

// File: rtl/sidf_care_mask.sv
// Builds the set of identifier bits that must compare equal.
// Span mode: the trailing ones of the word and the first zero above them are
// don't-care. v ^ (v+1) marks exactly those bits; an all-ones word wraps to 0
// and so marks every bit.
module sidf_care_mask #(
   parameter int unsigned SID_W = 32
) (
   input  logic [SID_W-1:0] word_i,
   input  logic             span_i,
   output logic [SID_W-1:0] care_o
);
   localparam logic [SID_W-1:0] ONE = SID_W'(1);

   logic [SID_W-1:0] inc;
   logic [SID_W-1:0] dont_care;

   always_comb begin
      inc       = word_i + ONE;
      dont_care = word_i ^ inc;
      care_o    = span_i ? ~dont_care : '1;
   end
endmodule

// File: rtl/sidf_cmp.sv
// One comparator: decides a single counter's hit from its effective settings.
module sidf_cmp
   import sidf_pkg::*;
#(
   parameter int unsigned SID_W = 32
) (
   input  logic [SID_W-1:0] sid_i,
   input  logic             en_i,
   input  logic             span_i,
   input  logic [SID_W-1:0] word_i,
   output logic             hit_o
);
   logic [SID_W-1:0] care;
   logic [SID_W-1:0] diff;

   sidf_care_mask #(.SID_W(SID_W)) u_mask (
      .word_i (word_i),
      .span_i (span_i),
      .care_o (care)
   );

   always_comb begin
      diff  = (sid_i ^ word_i) & care;
      hit_o = !en_i || (diff == '0);
   end
endmodule

// File: rtl/sid_filter.sv
module sid_filter
   import sidf_pkg::*;
#(
   parameter int unsigned SID_W    = 32,
   parameter int unsigned NCTR     = 4,
   parameter sel_mode_e   SEL_MODE = SEL_RUNTIME
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    glob_sel,
   input  logic [SID_W-1:0]        sid_in,
   input  logic [NCTR-1:0]         flt_en,
   input  logic [NCTR-1:0]         span_sel,
   input  logic [NCTR*WORD_W-1:0]  match_val,
   output logic [NCTR-1:0]         hit_now,
   output logic [NCTR-1:0]         hit_reg
);
   // Elaboration-time parameter checks
   if (SID_W < 1 || SID_W > WORD_W) begin : g_bad_sid_w
      $error("sid_filter: SID_W must lie in 1..%0d", WORD_W);
   end
   if (NCTR < 1 || NCTR > 64) begin : g_bad_nctr
      $error("sid_filter: NCTR must lie in 1..64");
   end

   flt_cfg_t cfg_raw [NCTR];
   flt_cfg_t cfg_eff [NCTR];

   // Unpack per-counter settings
   for (genvar i = 0; i < NCTR; i++) begin : g_unpack
      assign cfg_raw[i].en   = flt_en[i];
      assign cfg_raw[i].span = span_sel[i];
      assign cfg_raw[i].word = match_val[i*WORD_W +: WORD_W];
   end

   // Route settings according to the chosen variant
   for (genvar i = 0; i < NCTR; i++) begin : g_route
      if (SEL_MODE == SEL_RUNTIME) begin : g_rt
         assign cfg_eff[i] = glob_sel ? cfg_raw[0] : cfg_raw[i];
      end else if (SEL_MODE == SEL_SHARED) begin : g_sh
         assign cfg_eff[i] = cfg_raw[0];
      end else begin : g_lc
         assign cfg_eff[i] = cfg_raw[i];
      end
   end

   // One comparator per counter; only low SID_W bits of the word are used
   for (genvar i = 0; i < NCTR; i++) begin : g_cmp
      sidf_cmp #(.SID_W(SID_W)) u_cmp (
         .sid_i  (sid_in),
         .en_i   (cfg_eff[i].en),
         .span_i (cfg_eff[i].span),
         .word_i (cfg_eff[i].word[SID_W-1:0]),
         .hit_o  (hit_now[i])
      );
   end

   // Registered copy for the increment path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_reg <= '0;
      else        hit_reg <= hit_now;
   end
endmodule

// File: rtl/sid_filter_chk.sv
module sid_filter_chk
   import sidf_pkg::*;
#(
   parameter int unsigned SID_W    = 32,
   parameter int unsigned NCTR     = 4,
   parameter sel_mode_e   SEL_MODE = SEL_RUNTIME
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   glob_sel,
   input logic [SID_W-1:0]       sid_in,
   input logic [NCTR-1:0]        flt_en,
   input logic [NCTR-1:0]        span_sel,
   input logic [NCTR*WORD_W-1:0] match_val,
   input logic [NCTR-1:0]        hit_now,
   input logic [NCTR-1:0]        hit_reg
);
   logic              own0;
   logic [SID_W-1:0]  w0;
   assign own0 = (SEL_MODE == SEL_LOCAL) || (SEL_MODE == SEL_RUNTIME && !glob_sel);
   assign w0   = match_val[SID_W-1:0];

   // R1
   exact_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_en[0] && !span_sel[0]) |-> (hit_now[0] == (sid_in == w0)));

   // R4
   all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_en[0] && span_sel[0] && (&w0)) |-> hit_now[0]);

   // R5
   disabled_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_en[0] |-> hit_now[0]);

   // R6
   shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!own0 || SEL_MODE == SEL_SHARED) |-> (hit_now == {NCTR{hit_now[0]}}));

   // R8
   reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (hit_reg == $past(hit_now)));
endmodule

bind sid_filter sid_filter_chk #(.SID_W(SID_W), .NCTR(NCTR), .SEL_MODE(SEL_MODE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .glob_sel  (glob_sel),
   .sid_in    (sid_in),
   .flt_en    (flt_en),
   .span_sel  (span_sel),
   .match_val (match_val),
   .hit_now   (hit_now),
   .hit_reg   (hit_reg)
);

// File: tb/sid_filter_bench.sv
module sid_filter_bench;
   localparam int SW = 16;
   localparam int NC = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            glob_sel = 1'b0;
   logic [SW-1:0]   sid_in = '0;
   logic [NC-1:0]   flt_en = '0;
   logic [NC-1:0]   span_sel = '0;
   logic [NC*32-1:0] match_val = '0;
   logic [NC-1:0]   hit_now;
   logic [NC-1:0]   hit_reg;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   sid_filter #(.SID_W(SW), .NCTR(NC)) u_sid_filter (
      .clk(clk), .rst_n(rst_n), .glob_sel(glob_sel), .sid_in(sid_in),
      .flt_en(flt_en), .span_sel(span_sel), .match_val(match_val),
      .hit_now(hit_now), .hit_reg(hit_reg)
   );

   // Reference: scan for lowest zero, ignore bits up to and including it
   function automatic bit ref_hit(bit en, bit span, logic [31:0] word, logic [SW-1:0] sid);
      int y;
      if (!en) return 1'b1;
      if (!span) return sid == word[SW-1:0];
      y = SW;
      for (int b = 0; b < SW; b++) begin
         if (!word[b]) begin y = b + 1; break; end
      end
      for (int b = y; b < SW; b++) begin
         if (sid[b] != word[b]) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic logic [NC-1:0] ref_vec();
      logic [NC-1:0] r;
      for (int i = 0; i < NC; i++) begin
         int s;
         s = glob_sel ? 0 : i;
         r[i] = ref_hit(flt_en[s], span_sel[s], match_val[s*32 +: 32], sid_in);
      end
      return r;
   endfunction

   task automatic chk(logic [NC-1:0] got, logic [NC-1:0] exp, string req);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   // Inputs must already be set (driven after a negedge); checks both outputs
   task automatic run_vec(string req);
      logic [NC-1:0] e;
      #1;
      e = ref_vec();
      chk(hit_now, e, req);
      @(posedge clk); #1;
      chk(hit_reg, e, "R8");
      @(negedge clk);
   endtask

   task automatic set_ctr(int i, bit en, bit span, logic [31:0] w);
      flt_en[i] = en; span_sel[i] = span; match_val[i*32 +: 32] = w;
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'h1D5E);
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(hit_reg, '0, "R8");
      rst_n = 1'b1;
      @(negedge clk);

      // R1: exact compare, hit and one-bit miss
      for (int i = 0; i < NC; i++) set_ctr(i, 1, 0, 32'h0000_1234);
      sid_in = 16'h1234; run_vec("R1");
      chk(hit_now, '1, "R1");
      sid_in = 16'h1235; run_vec("R1");
      chk(hit_now, '0, "R1");

      // R3: 0x42 span on counter 1
      set_ctr(1, 1, 1, 32'h0000_0042);
      for (int s = 16'h40; s <= 16'h45; s++) begin
         sid_in = SW'(s); run_vec("R3");
         chk(hit_now[1], ((s == 16'h42) || (s == 16'h43)) ? 1'b1 : 1'b0, "R3");
      end

      // R2: three trailing ones -> low 4 bits ignored
      set_ctr(2, 1, 1, 32'h0000_ABC7);
      sid_in = 16'hABC8; run_vec("R2"); chk(hit_now[2], 1'b1, "R2");
      sid_in = 16'hABD0; run_vec("R2"); chk(hit_now[2], 1'b0, "R2");

      // R4: all-ones span word
      set_ctr(3, 1, 1, 32'h0000_FFFF);
      sid_in = 16'h0000; run_vec("R4"); chk(hit_now[3], 1'b1, "R4");
      sid_in = 16'h8001; run_vec("R4"); chk(hit_now[3], 1'b1, "R4");

      // R5: disabled filter with an exact word that would miss
      set_ctr(0, 0, 0, 32'h0000_0001);
      sid_in = 16'h7777; run_vec("R5"); chk(hit_now[0], 1'b1, "R5");

      // R9: junk above SID_W in an exact word
      set_ctr(0, 1, 0, 32'hABCD_0042);
      sid_in = 16'h0042; run_vec("R9"); chk(hit_now[0], 1'b1, "R9");

      // R6 / R7: counter 0 exact 0x10, others disabled
      set_ctr(0, 1, 0, 32'h0000_0010);
      for (int i = 1; i < NC; i++) set_ctr(i, 0, 0, 32'h0);
      sid_in = 16'h0011;
      glob_sel = 1'b1; run_vec("R6"); chk(hit_now, '0, "R6");
      glob_sel = 1'b0; run_vec("R7"); chk(hit_now, 4'b1110, "R7");

      // Random mix
      for (int n = 0; n < 400; n++) begin
         glob_sel = ($urandom % 4) == 0;
         for (int i = 0; i < NC; i++)
            set_ctr(i, ($urandom % 5) != 0, $urandom % 2, $urandom);
         if ($urandom % 2)
            sid_in = match_val[($urandom % NC)*32 +: SW] ^ SW'($urandom % 16);
         else
            sid_in = SW'($urandom);
         run_vec(glob_sel ? "R6" : "R2");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule